// File: doc/BRIEF.md
# Fourth-order cyclic cumulant estimator

This block takes a stream of signed complex baseband samples and estimates two fourth-order cyclic cumulants at one programmable cyclic frequency. For each accepted sample it forms the second-order powers y² and y·conj(y) and the fourth-order powers y⁴ and y³·conj(y). It then rotates them by a complex exponential: the fourth-order powers use four times the phase step and the second-order powers use twice the phase step. The rotated terms are summed over a record of N samples and divided by N to give cyclic moments. Products of the moments are then subtracted to give the C40 and C41 cumulants.

A start pulse loads the tuning word and opens a record. Samples enter through a valid/ready handshake. Ready is high only while a record is open and still short of N accepted samples. The block has no way to stall its pipeline, so it never applies back-pressure in the middle of a record. The source may leave gaps with valid low, and a gap has no effect on the result. When the record finishes, a one-cycle done strobe marks four complex-part result words. Sweeping the cyclic frequency and classifying the signal are left to surrounding logic.

Top module: `cyc_cum4`

## Requirements
- R1: While reset is held and after it is released, done is 0, s_ready is 0 and all four result words are 0.
- R2: A start pulse latches tune and opens a record, so s_ready is 1 in the cycle after it. A sample is accepted on a clock edge where s_valid and s_ready are both 1 and start is 0. Once exactly N = 2^LOG2N samples have been accepted, s_ready drops to 0 in the next cycle.
- R3: Samples offered while no record is open are ignored. s_ready stays 0, the held result words do not change, and the next record's result does not include them.
- R4: For sample x = I + jQ, the second-order terms are q2 = ((I²−Q²)>>>16, (2IQ)>>>16) and m = ((I²+Q²)>>>16, 0). Here >>> is an arithmetic (flooring) right shift.
- R5: The fourth-order terms are q2² for y⁴ and q2·m for y³·conj(y). Each complex product is formed as (ac−bd, ad+bc) and both parts are shifted right arithmetically by 16.
- R6: For the k-th accepted sample of a record (k from 0), the fourth-order phase is k·(tune<<2) mod 2²⁴ and the second-order phase is k·(tune<<1) mod 2²⁴. The table index is the top 10 bits of the phase. sin = round(32767·sin(2π·i/1024)), rounded half away from zero, and cos is the table entry at index (i+256) mod 1024. A term (a, b) is rotated to ((a·cos + b·sin)>>>15, (b·cos − a·sin)>>>15).
- R7: Each of the four rotated terms is summed exactly over the record, and the moment is the sum shifted right arithmetically by LOG2N.
- R8: With moments M4 (y⁴), M31 (y³·conj y), M2 (y²) and M11 (y·conj y): C40 = M4 − 3·((M2·M2)>>>16) and C41 = M31 − 3·((M2·M11)>>>16). The complex product and shift are those of R5. Each part is output as its low 32 bits, two's complement.
- R9: done is 1 for exactly one cycle, on the fourth rising edge after the edge that accepts the N-th sample. The result words change only on that edge and are held until the next done.
- R10: A start pulse during an open record discards everything accumulated so far, including samples still in the pipeline. It restarts the record at index 0 with the newly latched tune.
- R11: Gaps with s_valid low inside a record do not change the result. The sample index k counts accepted samples only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that opens or restarts a record |
| tune | input | 24 | Cyclic-frequency tuning word, round(2²⁴·α/fs), latched on start |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Record open and able to accept a sample |
| s_i | input | 16 | Sample real part, signed |
| s_q | input | 16 | Sample imaginary part, signed |
| done | output | 1 | One-cycle strobe, result words updated |
| c40_re | output | 32 | C40 real part, signed |
| c40_im | output | 32 | C40 imaginary part, signed |
| c41_re | output | 32 | C41 real part, signed |
| c41_im | output | 32 | C41 imaginary part, signed |

## Verification
A fault in the sample counter or in the record flag shows at s_ready within one cycle. s_ready either stays high past the N-th sample or never opens after start. Faults in the phase accumulators, the lookup or the power arithmetic do not show at the ports until done. There they appear as result words that differ from the arithmetic model. An accumulator or pipeline stage that is not cleared on start shows up only in the record that follows: an offset in its result, or a done strobe at the wrong time.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CW = 48;

  typedef struct packed {
    logic signed [CW-1:0] re;
    logic signed [CW-1:0] im;
  } cx_t;

  function automatic cx_t cx_mul_sh(input cx_t a, input cx_t b, input int sh);
    logic signed [2*CW-1:0] pr;
    logic signed [2*CW-1:0] pi;
    cx_t r;
    pr = a.re * b.re - a.im * b.im;
    pi = a.re * b.im + a.im * b.re;
    r.re = CW'(pr >>> sh);
    r.im = CW'(pi >>> sh);
    return r;
  endfunction

  function automatic cx_t cx_asr(input cx_t a, input int sh);
    cx_t r;
    r.re = a.re >>> sh;
    r.im = a.im >>> sh;
    return r;
  endfunction

  function automatic cx_t cx_add(input cx_t a, input cx_t b);
    cx_t r;
    r.re = a.re + b.re;
    r.im = a.im + b.im;
    return r;
  endfunction

  function automatic cx_t cx_sub3(input cx_t a, input cx_t b);
    cx_t r;
    r.re = a.re - 3 * b.re;
    r.im = a.im - 3 * b.im;
    return r;
  endfunction
endpackage

// File: rtl/cc_sincos.sv
module cc_sincos #(
  parameter int AW   = 10,
  parameter int AMPW = 16
) (
  input  logic [AW-1:0]          idx,
  output logic signed [AMPW-1:0] cos_o,
  output logic signed [AMPW-1:0] sin_o
);
  localparam int  DEPTH  = 1 << AW;
  localparam real AMP    = real'((1 << (AMPW-1)) - 1);
  localparam real TWO_PI = 6.283185307179586;

  logic signed [AMPW-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    localparam real V  = AMP * $sin(TWO_PI * real'(g) / real'(DEPTH));
    localparam int  RV = (V >= 0.0) ? $rtoi(V + 0.5) : $rtoi(V - 0.5);
    assign tbl[g] = AMPW'(RV);
  end

  assign sin_o = tbl[idx];
  assign cos_o = tbl[idx + AW'(DEPTH/4)];
endmodule

// File: rtl/cc_rotator.sv
module cc_rotator
  import cc_pkg::*;
#(
  parameter int AMPW = 16
) (
  input  cx_t                    d,
  input  logic signed [AMPW-1:0] c,
  input  logic signed [AMPW-1:0] s,
  output cx_t                    q
);
  logic signed [CW+AMPW:0] pre;
  logic signed [CW+AMPW:0] pim;

  // multiply by cos - j*sin, then drop the table scale
  always_comb begin
    pre  = d.re * c + d.im * s;
    pim  = d.im * c - d.re * s;
    q.re = CW'(pre >>> (AMPW-1));
    q.im = CW'(pim >>> (AMPW-1));
  end
endmodule

// File: rtl/cyc_cum4.sv
module cyc_cum4
  import cc_pkg::*;
#(
  parameter int DW    = 16,
  parameter int PHW   = 24,
  parameter int AW    = 10,
  parameter int AMPW  = 16,
  parameter int LOG2N = 10,
  parameter int OW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [PHW-1:0]       tune,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_i,
  input  logic signed [DW-1:0] s_q,
  output logic                 done,
  output logic signed [OW-1:0] c40_re,
  output logic signed [OW-1:0] c40_im,
  output logic signed [OW-1:0] c41_re,
  output logic signed [OW-1:0] c41_im
);
  localparam int N     = 1 << LOG2N;
  localparam int CNTW  = LOG2N + 1;
  localparam int PSH   = DW;
  localparam int LANES = 4;  // 0: y^4, 1: y^3 conj y, 2: y^2, 3: y conj y

  // ---------------- record control ----------------
  logic            active;
  logic [CNTW-1:0] cnt;
  logic [PHW-1:0]  tw_r, ph4, ph2;
  logic            take;

  assign s_ready = active;
  assign take    = s_valid && active && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      tw_r   <= '0;
      ph4    <= '0;
      ph2    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      tw_r   <= tune;
      ph4    <= '0;
      ph2    <= '0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      ph4 <= ph4 + (tw_r << 2);
      ph2 <= ph2 + (tw_r << 1);
      if (cnt == CNTW'(N-1)) active <= 1'b0;
    end
  end

  // R2
  ready_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> s_ready);
  // R2
  stop_after_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !start && cnt == CNTW'(N-1)) |=> !s_ready);
  // R3
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ready && !start) |=> $stable(cnt));

  // ---------------- stage 1: second-order powers ----------------
  cx_t x, xc, q2_c, m_c;
  always_comb begin
    x.re  = CW'(s_i);
    x.im  = CW'(s_q);
    xc.re = x.re;
    xc.im = -x.im;
    q2_c  = cx_mul_sh(x, x, PSH);
    m_c   = cx_mul_sh(x, xc, PSH);
  end

  logic          v1, l1;
  cx_t           q2_1, m_1;
  logic [AW-1:0] i4_1, i2_1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; l1 <= 1'b0;
      q2_1 <= '0; m_1 <= '0; i4_1 <= '0; i2_1 <= '0;
    end else begin
      v1 <= take;
      l1 <= take && (cnt == CNTW'(N-1));
      if (take) begin
        q2_1 <= q2_c;
        m_1  <= m_c;
        i4_1 <= ph4[PHW-1 -: AW];
        i2_1 <= ph2[PHW-1 -: AW];
      end
    end
  end

  // ---------------- stage 2: fourth-order powers ----------------
  logic          v2, l2;
  cx_t           q4a_2, q4b_2, q2_2, m_2;
  logic [AW-1:0] i4_2, i2_2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0; l2 <= 1'b0;
      q4a_2 <= '0; q4b_2 <= '0; q2_2 <= '0; m_2 <= '0; i4_2 <= '0; i2_2 <= '0;
    end else begin
      v2 <= v1 && !start;
      l2 <= l1 && !start;
      q4a_2 <= cx_mul_sh(q2_1, q2_1, PSH);
      q4b_2 <= cx_mul_sh(q2_1, m_1, PSH);
      q2_2  <= q2_1;
      m_2   <= m_1;
      i4_2  <= i4_1;
      i2_2  <= i2_1;
    end
  end

  // ---------------- rotation lanes ----------------
  logic signed [AMPW-1:0] cs4, sn4, cs2, sn2;
  cc_sincos #(.AW(AW), .AMPW(AMPW)) u_lut4 (.idx(i4_2), .cos_o(cs4), .sin_o(sn4));
  cc_sincos #(.AW(AW), .AMPW(AMPW)) u_lut2 (.idx(i2_2), .cos_o(cs2), .sin_o(sn2));

  cx_t lane_in  [LANES];
  cx_t lane_out [LANES];
  assign lane_in[0] = q4a_2;
  assign lane_in[1] = q4b_2;
  assign lane_in[2] = q2_2;
  assign lane_in[3] = m_2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g < 2) begin : g_fourth
      cc_rotator #(.AMPW(AMPW)) u_rot (.d(lane_in[g]), .c(cs4), .s(sn4), .q(lane_out[g]));
    end else begin : g_second
      cc_rotator #(.AMPW(AMPW)) u_rot (.d(lane_in[g]), .c(cs2), .s(sn2), .q(lane_out[g]));
    end
  end

  // ---------------- stage 3 and accumulation ----------------
  logic v3, l3, fin;
  cx_t  r3  [LANES];
  cx_t  acc [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v3 <= 1'b0; l3 <= 1'b0; fin <= 1'b0;
      for (int i = 0; i < LANES; i++) begin
        r3[i]  <= '0;
        acc[i] <= '0;
      end
    end else begin
      v3  <= v2 && !start;
      l3  <= l2 && !start;
      fin <= v3 && l3 && !start;
      for (int i = 0; i < LANES; i++) begin
        r3[i] <= lane_out[i];
        if (start)   acc[i] <= '0;
        else if (v3) acc[i] <= cx_add(acc[i], r3[i]);
      end
    end
  end

  // ---------------- cumulant combination ----------------
  cx_t mom [LANES];
  cx_t c40_c, c41_c;
  always_comb begin
    for (int i = 0; i < LANES; i++) mom[i] = cx_asr(acc[i], LOG2N);
    c40_c = cx_sub3(mom[0], cx_mul_sh(mom[2], mom[2], PSH));
    c41_c = cx_sub3(mom[1], cx_mul_sh(mom[2], mom[3], PSH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      c40_re <= '0; c40_im <= '0; c41_re <= '0; c41_im <= '0;
    end else begin
      done <= fin && !start;
      if (fin && !start) begin
        c40_re <= OW'(c40_c.re);
        c40_im <= OW'(c40_c.im);
        c41_re <= OW'(c41_c.re);
        c41_im <= OW'(c41_c.im);
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(c40_re) && $stable(c40_im) && $stable(c41_re) && $stable(c41_im)));
endmodule

// File: tb/tb_cyc_cum4.sv
module tb_cyc_cum4;
  localparam int PERIOD = 10;
  localparam int N      = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] tune = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [15:0] s_i = '0;
  logic signed [15:0] s_q = '0;
  logic done;
  logic signed [31:0] c40_re, c40_im, c41_re, c41_im;

  always #(PERIOD/2) clk = ~clk;

  cyc_cum4 dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tune(tune),
    .s_valid(s_valid), .s_ready(s_ready), .s_i(s_i), .s_q(s_q),
    .done(done), .c40_re(c40_re), .c40_im(c40_im), .c41_re(c41_re), .c41_im(c41_im)
  );

  int checks = 0;
  int fails  = 0;
  int si [N];
  int sq [N];
  longint e40r, e40i, e41r, e41i;
  int unsigned lf = 32'h1234_5678;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint lut(input int i);
    real v;
    v = 32767.0 * $sin(6.283185307179586 * real'(i) / 1024.0);
    return (v >= 0.0) ? longint'($rtoi(v + 0.5)) : longint'($rtoi(v - 0.5));
  endfunction

  function automatic int unsigned rnd();
    lf = lf * 32'd1103515245 + 32'd12345;
    return lf;
  endfunction

  task automatic fill(input int kind);
    for (int k = 0; k < N; k++) begin
      int unsigned r;
      r = rnd();
      case (kind)
        0: begin si[k] = 12000; sq[k] = -5000; end
        1: begin si[k] = r[20] ? 20000 : -20000; sq[k] = 0; end
        2: begin si[k] = r[21] ? 15000 : -15000; sq[k] = r[19] ? 15000 : -15000; end
        3: begin
             case (k % 3)
               0: begin si[k] = -32768; sq[k] = -32768; end
               1: begin si[k] = 32767;  sq[k] = -32768; end
               default: begin si[k] = -32768; sq[k] = 32767; end
             endcase
           end
        default: begin si[k] = int'($signed(r[31:16])); sq[k] = int'($signed(r[23:8])); end
      endcase
    end
  endtask

  // arithmetic model of R4..R8
  task automatic model(input longint tw);
    longint a0r = 0, a0i = 0, a1r = 0, a1i = 0, a2r = 0, a2i = 0, a3r = 0, a3i = 0;
    longint m0r, m0i, m1r, m1i, m2r, m2i, m3r, m3i, t0r, t0i, t1r, t1i;
    longint st4, st2;
    st4 = (tw << 2) & 64'hFFFFFF;
    st2 = (tw << 1) & 64'hFFFFFF;
    for (int k = 0; k < N; k++) begin
      longint ii, qq, q2r, q2i, mr, q4ar, q4ai, q4br, q4bi;
      longint i4, i2, c4, s4, c2, s2;
      ii = si[k]; qq = sq[k];
      q2r = (ii*ii - qq*qq) >>> 16;
      q2i = (2*ii*qq) >>> 16;
      mr  = (ii*ii + qq*qq) >>> 16;
      q4ar = (q2r*q2r - q2i*q2i) >>> 16;
      q4ai = (2*q2r*q2i) >>> 16;
      q4br = (q2r*mr) >>> 16;
      q4bi = (q2i*mr) >>> 16;
      i4 = ((longint'(k) * st4) & 64'hFFFFFF) >> 14;
      i2 = ((longint'(k) * st2) & 64'hFFFFFF) >> 14;
      c4 = lut(int'((i4 + 256) % 1024)); s4 = lut(int'(i4));
      c2 = lut(int'((i2 + 256) % 1024)); s2 = lut(int'(i2));
      a0r += (q4ar*c4 + q4ai*s4) >>> 15; a0i += (q4ai*c4 - q4ar*s4) >>> 15;
      a1r += (q4br*c4 + q4bi*s4) >>> 15; a1i += (q4bi*c4 - q4br*s4) >>> 15;
      a2r += (q2r*c2 + q2i*s2) >>> 15;   a2i += (q2i*c2 - q2r*s2) >>> 15;
      a3r += (mr*c2) >>> 15;             a3i += (-mr*s2) >>> 15;
    end
    m0r = a0r >>> 10; m0i = a0i >>> 10; m1r = a1r >>> 10; m1i = a1i >>> 10;
    m2r = a2r >>> 10; m2i = a2i >>> 10; m3r = a3r >>> 10; m3i = a3i >>> 10;
    t0r = (m2r*m2r - m2i*m2i) >>> 16; t0i = (m2r*m2i + m2i*m2r) >>> 16;
    t1r = (m2r*m3r - m2i*m3i) >>> 16; t1i = (m2r*m3i + m2i*m3r) >>> 16;
    e40r = longint'(int'(m0r - 3*t0r)); e40i = longint'(int'(m0i - 3*t0i));
    e41r = longint'(int'(m1r - 3*t1r)); e41i = longint'(int'(m1i - 3*t1i));
  endtask

  task automatic do_start(input logic [23:0] tw);
    @(negedge clk); start = 1'b1; tune = tw;
    @(negedge clk); start = 1'b0;
    chk("R2 ready after start", longint'(s_ready), 1);
  endtask

  task automatic send(input int n, input bit gaps);
    int k = 0;
    int cyc = 0;
    while (k < n) begin
      @(negedge clk);
      s_i = 16'(si[k]); s_q = 16'(sq[k]);
      s_valid = !(gaps && (cyc % 5 == 2));
      cyc++;
      if (s_valid && s_ready) k++;
      if (cyc > 8*N) begin
        chk("R2 handshake stalled", longint'(k), longint'(n));
        break;
      end
    end
    @(negedge clk); s_valid = 1'b0;
  endtask

  task automatic finish_and_check(input string tag);
    int early = 0;
    chk("R2 ready low after N samples", longint'(s_ready), 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (done) early++;
    end
    chk("R9 done not early", longint'(early), 0);
    @(negedge clk);
    chk("R9 done on 4th edge", longint'(done), 1);
    chk({tag, " c40_re"}, longint'(c40_re), e40r);
    chk({tag, " c40_im"}, longint'(c40_im), e40i);
    chk({tag, " c41_re"}, longint'(c41_re), e41r);
    chk({tag, " c41_im"}, longint'(c41_im), e41i);
    @(negedge clk);
    chk("R9 done single cycle", longint'(done), 0);
  endtask

  task automatic run_rec(input int kind, input logic [23:0] tw, input bit gaps, input string tag);
    fill(kind);
    model(longint'(tw));
    do_start(tw);
    send(N, gaps);
    finish_and_check(tag);
  endtask

  task automatic idle_garbage(input string tag);
    int rdy = 0;
    int moved = 0;
    logic signed [31:0] h0, h1;
    h0 = c40_re; h1 = c41_im;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      s_valid = 1'b1; s_i = 16'(rnd()); s_q = 16'(rnd());
      if (s_ready) rdy++;
      if (done) moved++;
    end
    @(negedge clk); s_valid = 1'b0;
    chk({tag, " ready stays low"}, longint'(rdy), 0);
    chk({tag, " no done"}, longint'(moved), 0);
    chk({tag, " c40_re held"}, longint'(c40_re), longint'(h0));
    chk({tag, " c41_im held"}, longint'(c41_im), longint'(h1));
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", longint'(done), 0);
    chk("R1 s_ready", longint'(s_ready), 0);
    chk("R1 c40_re", longint'(c40_re), 0);
    chk("R1 c41_im", longint'(c41_im), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", longint'(s_ready), 0);

    // R3: samples before any record are ignored
    idle_garbage("R3 idle");
    // R4 R5 R7 R8: constant sample, zero tuning
    run_rec(0, 24'd0, 1'b0, "R8 const");
    // R6: binary pattern at an eighth of the sample rate
    run_rec(1, 24'h200000, 1'b0, "R6 bpsk");
    // R11 R6: quaternary pattern with gaps, arbitrary tuning
    run_rec(2, 24'd3187671, 1'b1, "R11 qpsk gaps");
    // R3: samples between records do not disturb held results
    idle_garbage("R3 between");
    // R4 R5: full-scale corner values, largest tuning word
    run_rec(3, 24'hFFFFFF, 1'b0, "R5 extremes");

    // R10: restart in the middle of a record
    fill(4);
    model(longint'(24'd12345));
    do_start(24'd777);
    send(300, 1'b0);
    do_start(24'd12345);
    send(N, 1'b0);
    finish_and_check("R10 restart");

    // R7: random full-range record
    run_rec(4, 24'h0ABCDE, 1'b1, "R7 random");

    report();
  end
endmodule